// File: doc/BRIEF.md
# Single-Level Block Address Translator

This block turns a 64-bit virtual address into a 48-bit physical address with one table lookup. The table has 8192 entries of 64 bits. Each entry maps a 512 MB block, so the virtual space it covers is 42 bits wide. The top virtual bits choose one of two table bases: one for the lower half of the address space and one for the upper half. The block then reads a single descriptor through a request/response memory port. It checks that descriptor, builds the physical address, and checks that address against a configurable physical size limit.

A client hands over a virtual address and a write flag on a valid/ready channel. `req_ready` is high only while the block is idle. The block therefore back-pressures every new request until the current translation has reported, and at most one translation is in flight. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. On the memory side, `mem_req_valid` stays asserted with a stable address until the memory raises `mem_req_ready`. The descriptor is then taken on whichever later cycle shows `mem_rsp_valid`, so the read latency can be anything. The result comes back as a one-cycle `rsp_done` pulse with `rsp_pa` and `rsp_fault`. That pulse has no back-pressure.

Fault codes on `rsp_fault`: 0 none, 1 translation, 2 permission, 3 address size, 4 configuration.

Top module: `va_block_xlate`

## Requirements
- R1: After reset `req_ready` is 1 and `mem_req_valid` and `rsp_done` are 0. `req_ready` is 1 only while idle and drops right after a request is accepted.
- R2: The granule code `cfg_granule` must be 2'b11 (64K). Any other code ends the translation with fault 4 and issues no memory read.
- R3: Virtual bits [63:42] choose the base. All ones selects `cfg_base_hi`, and all zeros selects `cfg_base_lo`. Any mix ends the translation with fault 1 and issues no memory read.
- R4: Exactly one read is issued, at address base + VA[41:29]*8. `mem_req_valid` stays high with a stable address until `mem_req_ready`, and drops after the handshake.
- R5: The descriptor is accepted on any cycle with `mem_rsp_valid` after the read handshake, whatever the latency.
- R6: A descriptor whose bits [1:0] are not 2'b01 ends the translation with fault 1.
- R7: Descriptor bit 7 marks the block read-only. A write to such a block gives fault 2. A read from it is allowed.
- R8: On success `rsp_pa` = {descriptor[47:29], VA[28:0]} and `rsp_fault` = 0.
- R9: `cfg_pa_size` sets the physical size limit: 000 is 32 bits, 001 is 36, 010 is 40, 011 is 42, 100 is 44, and 101, 110 and 111 are 48. A result with any bit set at or above that limit gives fault 3.
- R10: Faults are ranked configuration > address range > descriptor type > permission > size. On any fault `rsp_pa` is 0.
- R11: Every translation ends with exactly one single-cycle `rsp_done` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block idle, can accept a request |
| req_va | input | 64 | Virtual address |
| req_write | input | 1 | Request is a write |
| cfg_base_lo | input | 48 | Table base for the lower address half |
| cfg_base_hi | input | 48 | Table base for the upper address half |
| cfg_granule | input | 2 | Granule code (only 2'b11 accepted) |
| cfg_pa_size | input | 3 | Physical address size code |
| mem_req_valid | output | 1 | Descriptor read request valid |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 48 | Descriptor byte address |
| mem_rsp_valid | input | 1 | Descriptor data valid |
| mem_rsp_data | input | 64 | Descriptor data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_pa | output | 48 | Physical address (0 on fault) |
| rsp_fault | output | 3 | Fault code |

## Verification
The bench uses the default parameters: a 64-bit virtual address, a 48-bit physical address, a 13-bit index and a 29-bit block offset. It sweeps every granule code, and every size code against twelve indices including 0 and 8191. Each index is tried in the lower half, the upper half and with a mixed top, for both reads and writes. The model memory derives the descriptor type, the read-only bit and high output bits from the entry address. This brings every fault kind, every fault ranking and every size boundary within reach. The model memory also varies its grant and data latency between translations.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  typedef enum logic [2:0] {
    FLT_NONE  = 3'd0,
    FLT_XLATE = 3'd1,
    FLT_PERM  = 3'd2,
    FLT_ASIZE = 3'd3,
    FLT_CFG   = 3'd4
  } fault_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SELECT, ST_READ_REQ, ST_READ_WAIT, ST_CHECK, ST_RESPOND
  } xst_e;

  localparam logic [1:0] GRAN_64K   = 2'b11;
  localparam logic [1:0] DESC_BLOCK = 2'b01;

  // Width in bits allowed by a physical size code.
  function automatic int pa_bits(input logic [2:0] code);
    int b;
    case (code)
      3'd0:    b = 32;
      3'd1:    b = 36;
      3'd2:    b = 40;
      3'd3:    b = 42;
      3'd4:    b = 44;
      default: b = 48;
    endcase
    return b;
  endfunction
endpackage

// File: rtl/xlate_select.sv
module xlate_select #(
  parameter int VA_W   = 64,
  parameter int PA_W   = 48,
  parameter int OFF_W  = 29,
  parameter int IDX_W  = 13,
  parameter int ENT_SH = 3
) (
  input  logic [VA_W-1:0] va,
  input  logic [PA_W-1:0] base_lo,
  input  logic [PA_W-1:0] base_hi,
  output logic            range_ok,
  output logic [PA_W-1:0] entry_addr
);
  localparam int TOP_LO = OFF_W + IDX_W;
  localparam int TOP_W  = VA_W - TOP_LO;

  logic [TOP_W-1:0] top;
  logic [IDX_W-1:0] idx;
  logic             upper;
  logic [PA_W-1:0]  base;

  assign top        = va[VA_W-1:TOP_LO];
  assign idx        = va[TOP_LO-1:OFF_W];
  assign upper      = &top;
  assign range_ok   = upper | ~|top;
  assign base       = upper ? base_hi : base_lo;
  assign entry_addr = base + (PA_W'(idx) << ENT_SH);
endmodule

// File: rtl/xlate_limit.sv
module xlate_limit #(
  parameter int PA_W = 48
) (
  input  logic [PA_W-1:0] pa,
  input  logic [2:0]      size_code,
  output logic            over
);
  import xlate_pkg::*;

  logic [PA_W-1:0] mask;

  always_comb begin
    for (int i = 0; i < PA_W; i++) begin
      mask[i] = (i < pa_bits(size_code));
    end
  end

  assign over = |(pa & ~mask);
endmodule

// File: rtl/xlate_check.sv
module xlate_check #(
  parameter int PA_W   = 48,
  parameter int OFF_W  = 29,
  parameter int DESC_W = 64,
  parameter int RO_BIT = 7
) (
  input  logic [DESC_W-1:0]  desc,
  input  logic [OFF_W-1:0]   va_off,
  input  logic               is_write,
  input  logic [2:0]         size_code,
  output xlate_pkg::fault_e  fault,
  output logic [PA_W-1:0]    pa
);
  import xlate_pkg::*;

  logic over;

  assign pa = {desc[PA_W-1:OFF_W], va_off};

  xlate_limit #(.PA_W(PA_W)) u_limit (
    .pa        (pa),
    .size_code (size_code),
    .over      (over)
  );

  always_comb begin
    if (desc[1:0] != DESC_BLOCK)        fault = FLT_XLATE;
    else if (is_write && desc[RO_BIT])  fault = FLT_PERM;
    else if (over)                      fault = FLT_ASIZE;
    else                                fault = FLT_NONE;
  end
endmodule

// File: rtl/va_block_xlate.sv
module va_block_xlate #(
  parameter int VA_W   = 64,
  parameter int PA_W   = 48,
  parameter int OFF_W  = 29,
  parameter int IDX_W  = 13,
  parameter int DESC_W = 64,
  parameter int RO_BIT = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_va,
  input  logic              req_write,
  input  logic [PA_W-1:0]   cfg_base_lo,
  input  logic [PA_W-1:0]   cfg_base_hi,
  input  logic [1:0]        cfg_granule,
  input  logic [2:0]        cfg_pa_size,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [PA_W-1:0]   mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [DESC_W-1:0] mem_rsp_data,
  output logic              rsp_done,
  output logic [PA_W-1:0]   rsp_pa,
  output logic [2:0]        rsp_fault
);
  import xlate_pkg::*;

  localparam int ENT_SH = $clog2(DESC_W / 8);

  xst_e              state;
  logic [VA_W-1:0]   va_q;
  logic              wr_q;
  logic [PA_W-1:0]   addr_q;
  logic [DESC_W-1:0] desc_q;
  fault_e            fault_q;
  logic [PA_W-1:0]   pa_q;

  logic              range_ok;
  logic [PA_W-1:0]   entry_addr;
  fault_e            chk_fault;
  logic [PA_W-1:0]   chk_pa;

  xlate_select #(
    .VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .ENT_SH(ENT_SH)
  ) u_select (
    .va         (va_q),
    .base_lo    (cfg_base_lo),
    .base_hi    (cfg_base_hi),
    .range_ok   (range_ok),
    .entry_addr (entry_addr)
  );

  xlate_check #(
    .PA_W(PA_W), .OFF_W(OFF_W), .DESC_W(DESC_W), .RO_BIT(RO_BIT)
  ) u_check (
    .desc      (desc_q),
    .va_off    (va_q[OFF_W-1:0]),
    .is_write  (wr_q),
    .size_code (cfg_pa_size),
    .fault     (chk_fault),
    .pa        (chk_pa)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      va_q    <= '0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      desc_q  <= '0;
      fault_q <= FLT_NONE;
      pa_q    <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            va_q  <= req_va;
            wr_q  <= req_write;
            state <= ST_SELECT;
          end
        end
        ST_SELECT: begin
          if (cfg_granule != GRAN_64K) begin
            fault_q <= FLT_CFG;
            pa_q    <= '0;
            state   <= ST_RESPOND;
          end else if (!range_ok) begin
            fault_q <= FLT_XLATE;
            pa_q    <= '0;
            state   <= ST_RESPOND;
          end else begin
            addr_q <= entry_addr;
            state  <= ST_READ_REQ;
          end
        end
        ST_READ_REQ: begin
          if (mem_req_ready) state <= ST_READ_WAIT;
        end
        ST_READ_WAIT: begin
          if (mem_rsp_valid) begin
            desc_q <= mem_rsp_data;
            state  <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          fault_q <= chk_fault;
          pa_q    <= (chk_fault == FLT_NONE) ? chk_pa : '0;
          state   <= ST_RESPOND;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready     = (state == ST_IDLE);
  assign mem_req_valid = (state == ST_READ_REQ);
  assign mem_req_addr  = addr_q;
  assign rsp_done      = (state == ST_RESPOND);
  assign rsp_pa        = pa_q;
  assign rsp_fault     = fault_q;
endmodule

// File: rtl/va_block_xlate_chk.sv
module va_block_xlate_chk #(
  parameter int VA_W  = 64,
  parameter int PA_W  = 48,
  parameter int OFF_W = 29,
  parameter int IDX_W = 13
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic [VA_W-1:0] req_va,
  input logic [1:0]      cfg_granule,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic [PA_W-1:0] mem_req_addr,
  input logic            rsp_done,
  input logic [PA_W-1:0] rsp_pa,
  input logic [2:0]      rsp_fault
);
  localparam int TOP_LO = OFF_W + IDX_W;

  logic [VA_W-1:0] va_seen;
  logic            no_read;
  logic            busy;
  logic            top_mixed;

  assign top_mixed = !(&req_va[VA_W-1:TOP_LO]) && (|req_va[VA_W-1:TOP_LO]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      va_seen <= '0;
      no_read <= 1'b0;
      busy    <= 1'b0;
    end else if (req_valid && req_ready) begin
      va_seen <= req_va;
      no_read <= (cfg_granule != 2'b11) || top_mixed;
      busy    <= 1'b1;
    end else if (rsp_done) begin
      busy <= 1'b0;
    end
  end

  AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !busy);  // R1
  AST_NO_READ_ON_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    no_read && busy |-> !mem_req_valid);  // R3
  AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));  // R4
  AST_SINGLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_ready |=> !mem_req_valid);  // R4
  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done && rsp_fault == 3'd0 |-> rsp_pa[OFF_W-1:0] == va_seen[OFF_W-1:0]);  // R8
  AST_FAULT_ZERO_PA: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done && rsp_fault != 3'd0 |-> rsp_pa == '0);  // R10
  AST_FAULT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> rsp_fault <= 3'd4);  // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);  // R11
endmodule

bind va_block_xlate va_block_xlate_chk #(
  .VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W), .IDX_W(IDX_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_va        (req_va),
  .cfg_granule   (cfg_granule),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .rsp_done      (rsp_done),
  .rsp_pa        (rsp_pa),
  .rsp_fault     (rsp_fault)
);

// File: tb/sim_va_block_xlate.sv
`timescale 1ns/1ps
module sim_va_block_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_va = '0;
  logic        req_write = 1'b0;
  logic [47:0] cfg_base_lo = 48'h0012_3450_0000;
  logic [47:0] cfg_base_hi = 48'h0A00_0080_0000;
  logic [1:0]  cfg_granule = 2'b11;
  logic [2:0]  cfg_pa_size = 3'd5;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [47:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        rsp_done;
  logic [47:0] rsp_pa;
  logic [2:0]  rsp_fault;

  int total = 0;
  int bad = 0;
  int n_reads = 0;
  int cycles = 0;
  logic [47:0] cap_addr = '0;

  always #2.5 clk = ~clk;

  va_block_xlate u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_va(req_va), .req_write(req_write), .cfg_base_lo(cfg_base_lo),
    .cfg_base_hi(cfg_base_hi), .cfg_granule(cfg_granule), .cfg_pa_size(cfg_pa_size),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .rsp_done(rsp_done), .rsp_pa(rsp_pa),
    .rsp_fault(rsp_fault)
  );

  function automatic logic [63:0] desc_of(input logic [47:0] a);
    logic [63:0] d;
    logic [18:0] hi;
    hi = 19'(a[47:3] * 45'd2654435 + 45'(a[47:29]));
    d = {16'h5A5A, hi, 27'h0, a[4:3]};
    d[7] = a[5];
    return d;
  endfunction

  function automatic int lim_bits(input logic [2:0] c);
    case (c)
      3'd0: return 32;
      3'd1: return 36;
      3'd2: return 40;
      3'd3: return 42;
      3'd4: return 44;
      default: return 48;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // model memory with changing grant and data latency
  initial begin
    int phase = 0;
    int gdly = 1;
    int rdly = 0;
    int seed = 0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      case (phase)
        0: if (mem_req_valid) begin
             if (gdly == 0) begin
               mem_req_ready = 1'b1;
               cap_addr = mem_req_addr;
               phase = 1;
             end else gdly--;
           end
        1: begin
             mem_req_ready = 1'b0;
             n_reads++;
             seed++;
             rdly = seed % 4;
             phase = 2;
           end
        default: if (rdly == 0) begin
             mem_rsp_valid = 1'b1;
             mem_rsp_data = desc_of(cap_addr);
             gdly = (seed * 5) % 3;
             phase = 0;
           end else rdly--;
      endcase
    end
  end

  // watchdog
  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        total++; bad++;
        $display("FAIL watchdog act=%0d exp<150000", cycles);
        finish_run();
      end
    end
  end

  task automatic run_one(input logic [63:0] va, input bit wr, input int half);
    logic [47:0] base, eaddr, pa;
    logic [63:0] d;
    logic [2:0]  ef;
    logic [47:0] epa;
    int          r0, wait_n;
    bit          reads;
    base  = (half == 1) ? cfg_base_hi : cfg_base_lo;
    eaddr = base + (48'(va[41:29]) << 3);
    epa   = '0;
    reads = 1'b0;
    if (cfg_granule != 2'b11) ef = 3'd4;                 // R2
    else if (half == 2) ef = 3'd1;                       // R3
    else begin
      reads = 1'b1;
      d = desc_of(eaddr);
      pa = {d[47:29], va[28:0]};
      if (d[1:0] != 2'b01) ef = 3'd1;                    // R6
      else if (wr && d[7]) ef = 3'd2;                    // R7
      else if ((pa >> lim_bits(cfg_pa_size)) != 0) ef = 3'd3;  // R9
      else begin ef = 3'd0; epa = pa; end                // R8
    end
    r0 = n_reads;
    @(negedge clk);
    req_va = va; req_write = wr; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R1 ready low while busy", 64'(req_ready), 64'd0);
    wait_n = 0;
    while (!rsp_done && wait_n < 100) begin
      @(negedge clk);
      wait_n++;
    end
    chk(rsp_done == 1'b1, "R5 done seen", 64'(rsp_done), 64'd1);
    chk(rsp_fault == ef, "R10 fault code", 64'(rsp_fault), 64'(ef));
    chk(rsp_pa == epa, "R8 pa", 64'(rsp_pa), 64'(epa));
    chk(n_reads - r0 == (reads ? 1 : 0), "R4 read count",
        64'(n_reads - r0), 64'(reads ? 1 : 0));
    if (reads) chk(cap_addr == eaddr, "R4 entry addr", 64'(cap_addr), 64'(eaddr));
    @(negedge clk);
    chk(rsp_done == 1'b0, "R11 single pulse", 64'(rsp_done), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R1 reset ready", 64'(req_ready), 64'd1);
    chk(mem_req_valid == 1'b0, "R1 reset mem valid", 64'(mem_req_valid), 64'd0);
    chk(rsp_done == 1'b0, "R1 reset done", 64'(rsp_done), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 idle ready", 64'(req_ready), 64'd1);

    // R2: every granule code other than 64K
    for (int g = 0; g < 3; g++) begin
      cfg_granule = 2'(g);
      for (int h = 0; h < 3; h++) begin
        run_one({(h == 1) ? 22'h3FFFFF : (h == 2 ? 22'h001000 : 22'h0), 13'd5, 29'h1234}, 1'b0, h);
      end
    end
    cfg_granule = 2'b11;

    // R3 R6 R7 R8 R9: size codes x indices x halves x direction
    for (int s = 0; s < 8; s++) begin
      cfg_pa_size = 3'(s);
      for (int k = 0; k < 12; k++) begin
        logic [12:0] idx;
        idx = (k == 0) ? 13'd0 : (k == 11) ? 13'd8191 : 13'(k * 701);
        for (int h = 0; h < 3; h++) begin
          for (int w = 0; w < 2; w++) begin
            logic [21:0] top;
            top = (h == 1) ? 22'h3FFFFF : (h == 2) ? 22'(22'h000800 << k % 8) : 22'h0;
            run_one({top, idx, 29'(idx * 7919 + s)}, w[0], h);
          end
        end
      end
    end
    finish_run();
  end
endmodule